// File: doc/BRIEF.md
# Interrupt Acceptance Holdoff Controller

This block sits between a prioritized interrupt request and the fetch stage of a processor. Each cycle it decides whether the pending request may be taken and steered into fetch. It keeps a current priority level. A request is taken only when its priority is strictly above that level. On acceptance the level rises to the priority just taken, and the previous level is saved.

A deferral happens when an instruction older than a taken interrupt turns interrupts off while the handler is already being fetched. The controller then asks the front end to flush the handler instructions and restores the saved level. It also starts a holdoff counter that refuses every new acceptance until the counter reaches zero. Without this pause the core could take the interrupt again at once, flush again, and never make progress.

The holdoff length starts at a minimum. Each further deferral doubles it, up to a ceiling. Executing an interrupt-enable instruction returns the length to the minimum. A separate level-load input lets the core lower the level, for example on return from a handler.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `accept_o`, `accept_prio_o`, `flush_o`, `holdoff_active_o` and `cur_level_o` to 0. It also sets the holdoff length to the minimum of 10 cycles.
- R2: A request with `req_valid_i` high is accepted only if `req_prio_i` is strictly greater than `cur_level_o`. A request at or below the level is ignored. Acceptance shows one cycle after the request as `accept_o`=1, with `accept_prio_o` equal to the request priority. When there is no acceptance, `accept_prio_o` is 0.
- R3: On acceptance, `cur_level_o` takes the accepted priority in the same cycle that `accept_o` rises.
- R4: A `defer_i` pulse gives a one-cycle `flush_o` pulse in the following cycle. In that same cycle, `cur_level_o` returns to the level held just before the most recent acceptance.
- R5: After a deferral, `holdoff_active_o` stays high for exactly the current holdoff length in cycles, and no acceptance happens during that time. A request still qualifying when the holdoff ends is accepted one cycle after `holdoff_active_o` falls.
- R6: Each deferral after the first doubles the holdoff length, saturating at 160. From reset the sequence is 10, 20, 40, 80, 160, 160.
- R7: A deferral that arrives while the holdoff is running restarts the counter at the current, longer length.
- R8: A `irq_enable_exec_i` pulse returns the holdoff length to 10. If it comes in the same cycle as a deferral, that deferral still uses the length held before, and the next deferral uses 10.
- R9: When neither a deferral nor an acceptance happens in the cycle, `lvl_set_valid_i` loads `lvl_set_val_i` into `cur_level_o` one cycle later.
- R10: A deferral in the same cycle as a qualifying request suppresses that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | An interrupt request is pending |
| req_prio_i | input | 5 | Priority of the pending request |
| defer_i | input | 1 | An older instruction disabled interrupts after a take |
| irq_enable_exec_i | input | 1 | An interrupt-enable instruction executed |
| lvl_set_valid_i | input | 1 | Load a new current level |
| lvl_set_val_i | input | 5 | Level value to load |
| accept_o | output | 1 | One-cycle acceptance pulse |
| accept_prio_o | output | 5 | Priority accepted, 0 when idle |
| flush_o | output | 1 | Flush the fetched handler instructions |
| holdoff_active_o | output | 1 | The holdoff counter is running |
| cur_level_o | output | 5 | Current priority level |

## Verification
Two pairs of functions can land in the same cycle. First, a deferral can coincide with a request that would otherwise qualify. The bench holds a high-priority request across the deferral cycle and the whole holdoff. It expects no acceptance pulse until the cycle after the holdoff ends, and then exactly one. Second, an enable instruction can coincide with a deferral. The bench pulses both together and expects that holdoff to run at the prior length, with the following deferral at the minimum.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
   // Growth policy for the holdoff length after a repeated deferral.
   typedef enum logic {
      HOLD_FIXED  = 1'b0,
      HOLD_DOUBLE = 1'b1
   } hold_mode_e;
endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
   parameter int PRIO_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid_i,
   input  logic [PRIO_W-1:0] req_prio_i,
   input  logic              blocked_i,
   input  logic              defer_i,
   input  logic              lvl_set_valid_i,
   input  logic [PRIO_W-1:0] lvl_set_val_i,
   output logic              accept_o,
   output logic [PRIO_W-1:0] accept_prio_o,
   output logic [PRIO_W-1:0] level_o
);
   logic [PRIO_W-1:0] level_q, saved_q, acc_prio_q;
   logic              acc_q;
   logic              take;

   // Strict comparison: equal priority never preempts.
   assign take = req_valid_i && !blocked_i && (req_prio_i > level_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q    <= '0;
         saved_q    <= '0;
         acc_q      <= 1'b0;
         acc_prio_q <= '0;
      end else begin
         acc_q      <= take;
         acc_prio_q <= take ? req_prio_i : '0;
         if (defer_i) begin
            level_q <= saved_q;
         end else if (take) begin
            saved_q <= level_q;
            level_q <= req_prio_i;
         end else if (lvl_set_valid_i) begin
            level_q <= lvl_set_val_i;
         end
      end
   end

   assign accept_o      = acc_q;
   assign accept_prio_o = acc_prio_q;
   assign level_o       = level_q;

   p_strict_above_r2: assert property (@(posedge clk) disable iff (rst)
      acc_q |-> ($past(req_prio_i) > $past(level_q)));

   p_level_follows_r3: assert property (@(posedge clk) disable iff (rst)
      acc_q |-> (level_q == acc_prio_q));

   p_restore_r4: assert property (@(posedge clk) disable iff (rst)
      defer_i |=> (level_q == $past(saved_q)));
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer
   import irq_holdoff_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter int         MIN_HOLD = 10,
   parameter int         MAX_HOLD = 160,
   parameter hold_mode_e MODE     = HOLD_DOUBLE
) (
   input  logic clk,
   input  logic rst,
   input  logic defer_i,
   input  logic enable_exec_i,
   output logic active_o
);
   localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_HOLD);
   localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_HOLD);

   logic [CNT_W-1:0] cnt_q, len_q, len_grow;

   generate
      if (MODE == HOLD_DOUBLE) begin : g_double
         logic [CNT_W:0] twice;
         assign twice    = {len_q, 1'b0};
         assign len_grow = (twice > {1'b0, MAX_L}) ? MAX_L : twice[CNT_W-1:0];
      end else begin : g_fixed
         assign len_grow = len_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         len_q <= MIN_L;
      end else begin
         if (defer_i) cnt_q <= len_q;
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;

         if (enable_exec_i) len_q <= MIN_L;
         else if (defer_i) len_q <= len_grow;
      end
   end

   assign active_o = (cnt_q != '0);

   p_len_bounds_r6: assert property (@(posedge clk) disable iff (rst)
      (len_q >= MIN_L) && (len_q <= MAX_L));

   p_restart_r7: assert property (@(posedge clk) disable iff (rst)
      defer_i |=> (cnt_q == $past(len_q)));

   p_len_min_r8: assert property (@(posedge clk) disable iff (rst)
      enable_exec_i |=> (len_q == MIN_L));

   p_countdown_r5: assert property (@(posedge clk) disable iff (rst)
      ((cnt_q != '0) && !defer_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl
   import irq_holdoff_pkg::*;
#(
   parameter int         PRIO_W   = 5,
   parameter int         CNT_W    = 8,
   parameter int         MIN_HOLD = 10,
   parameter int         MAX_HOLD = 160,
   parameter hold_mode_e MODE     = HOLD_DOUBLE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid_i,
   input  logic [PRIO_W-1:0] req_prio_i,
   input  logic              defer_i,
   input  logic              irq_enable_exec_i,
   input  logic              lvl_set_valid_i,
   input  logic [PRIO_W-1:0] lvl_set_val_i,
   output logic              accept_o,
   output logic [PRIO_W-1:0] accept_prio_o,
   output logic              flush_o,
   output logic              holdoff_active_o,
   output logic [PRIO_W-1:0] cur_level_o
);
   generate
      if (PRIO_W < 1) begin : g_bad_prio
         $error("PRIO_W must be at least 1");
      end
      if (MIN_HOLD < 1 || MAX_HOLD < MIN_HOLD) begin : g_bad_hold
         $error("holdoff bounds out of order");
      end
      if (MAX_HOLD >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for MAX_HOLD");
      end
   endgenerate

   logic hold_run, flush_q;

   irq_holdoff_timer #(
      .CNT_W(CNT_W), .MIN_HOLD(MIN_HOLD), .MAX_HOLD(MAX_HOLD), .MODE(MODE)
   ) u_timer (
      .clk(clk), .rst(rst), .defer_i(defer_i),
      .enable_exec_i(irq_enable_exec_i), .active_o(hold_run)
   );

   irq_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
      .clk(clk), .rst(rst),
      .req_valid_i(req_valid_i), .req_prio_i(req_prio_i),
      .blocked_i(hold_run || defer_i), .defer_i(defer_i),
      .lvl_set_valid_i(lvl_set_valid_i), .lvl_set_val_i(lvl_set_val_i),
      .accept_o(accept_o), .accept_prio_o(accept_prio_o), .level_o(cur_level_o)
   );

   always_ff @(posedge clk) begin
      if (rst) flush_q <= 1'b0;
      else     flush_q <= defer_i;
   end

   assign flush_o          = flush_q;
   assign holdoff_active_o = hold_run;

   p_flush_follows_r4: assert property (@(posedge clk) disable iff (rst)
      defer_i |=> flush_o);

   p_hold_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      holdoff_active_o |=> !accept_o);

   p_defer_blocks_r10: assert property (@(posedge clk) disable iff (rst)
      defer_i |=> !accept_o);
endmodule

// File: tb/test_irq_holdoff_ctrl.sv
`timescale 1ns/1ps
module test_irq_holdoff_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0, defer = 1'b0, en_exec = 1'b0, lset_v = 1'b0;
   logic [4:0] req_prio = '0, lset_val = '0;
   logic       accept, flush, hold_act;
   logic [4:0] accept_prio, cur_level;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_holdoff_ctrl i_irq_holdoff_ctrl (
      .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_prio_i(req_prio),
      .defer_i(defer), .irq_enable_exec_i(en_exec),
      .lvl_set_valid_i(lset_v), .lvl_set_val_i(lset_val),
      .accept_o(accept), .accept_prio_o(accept_prio), .flush_o(flush),
      .holdoff_active_o(hold_act), .cur_level_o(cur_level)
   );

   // {level to load, request priority, expected acceptance}
   localparam logic [10:0] VEC [8] = '{
      {5'd0,  5'd1,  1'b1}, {5'd0,  5'd0,  1'b0}, {5'd5,  5'd5,  1'b0},
      {5'd5,  5'd6,  1'b1}, {5'd7,  5'd3,  1'b0}, {5'd30, 5'd31, 1'b1},
      {5'd31, 5'd31, 1'b0}, {5'd12, 5'd20, 1'b1}
   };

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Pulse defer; check the flush and level, then measure the holdoff length.
   task automatic do_defer(input int exp_len, input int exp_lvl, input string rq);
      int n;
      defer = 1'b1;
      step();
      defer = 1'b0;
      en_exec = 1'b0;
      chk("R4", "flush pulse", flush, 1);
      chk("R4", "level restored", cur_level, exp_lvl);
      n = 0;
      while (hold_act && n < 1000) begin
         n++;
         if (accept) chk("R5", "accept during holdoff", 1, 0);
         step();
      end
      chk(rq, "holdoff length", n, exp_len);
      chk("R4", "flush ends", flush, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "accept", accept, 0);
      chk("R1", "accept_prio", accept_prio, 0);
      chk("R1", "flush", flush, 0);
      chk("R1", "holdoff", hold_act, 0);
      chk("R1", "level", cur_level, 0);
      rst = 1'b0;
      step();

      // Table walk: R2 compare, R3 level load, R9 level set
      foreach (VEC[i]) begin
         lset_v = 1'b1;
         lset_val = VEC[i][10:6];
         step();
         lset_v = 1'b0;
         chk("R9", "level loaded", cur_level, VEC[i][10:6]);
         req_valid = 1'b1;
         req_prio = VEC[i][5:1];
         step();
         req_valid = 1'b0;
         chk("R2", "accept", accept, VEC[i][0]);
         chk("R2", "accept_prio", accept_prio, VEC[i][0] ? VEC[i][5:1] : 0);
         chk("R3", "level", cur_level, VEC[i][0] ? VEC[i][5:1] : VEC[i][10:6]);
         step();
         chk("R2", "single pulse", accept, 0);
      end

      // Take priority 3 from level 0, then defer with priority 31 held (R5, R10)
      lset_v = 1'b1; lset_val = 5'd0;
      step();
      lset_v = 1'b0;
      req_valid = 1'b1; req_prio = 5'd3;
      step();
      chk("R2", "accept 3", accept, 1);
      req_prio = 5'd31;
      do_defer(10, 0, "R5");
      step();
      chk("R5", "accept after holdoff", accept, 1);
      chk("R5", "prio after holdoff", accept_prio, 31);
      req_valid = 1'b0;
      step();

      // Doubling and saturation (R6)
      do_defer(20, 0, "R6");
      do_defer(40, 0, "R6");
      do_defer(80, 0, "R6");
      do_defer(160, 0, "R6");
      do_defer(160, 0, "R6");

      // Enable instruction resets the length (R8)
      en_exec = 1'b1;
      step();
      en_exec = 1'b0;
      do_defer(10, 0, "R8");
      en_exec = 1'b1;
      do_defer(20, 0, "R8");
      do_defer(10, 0, "R8");

      // Restart while running (R7): length is now 20, growing to 40
      defer = 1'b1;
      step();
      defer = 1'b0;
      chk("R7", "first flush", flush, 1);
      repeat (3) step();
      chk("R7", "still holding", hold_act, 1);
      do_defer(40, 0, "R7");

      // Same-cycle deferral and qualifying request (R10)
      req_valid = 1'b1; req_prio = 5'd9; defer = 1'b1;
      step();
      defer = 1'b0; req_valid = 1'b0;
      chk("R10", "accept suppressed", accept, 0);
      chk("R10", "level unchanged", cur_level, 0);
      while (hold_act) step();
      step();
      chk("R10", "no late accept", accept, 0);

      finish_run();
   end
endmodule